// File: doc/BRIEF.md
# Dual-Window On-Chip Memory Decoder

This block holds a small on-chip RAM and lets it appear at two places in a 32-bit address map. One place serves instruction fetches and the other serves data accesses. Each window has a base register, which places it on a 64 MB boundary, and a control register, whose top bit turns the window on. Software programs all four registers through a narrow register port.

The decoder takes one bus access per cycle. Each access carries an address, a side (instruction or data) and a read/write flag. The decoder compares the address only against the window that belongs to that side. On a hit it reports the hit, gives the byte offset into the RAM, and performs the RAM access. Read data comes back one cycle later with a valid strobe.

Both windows map onto the same physical storage. A word written through one window can be read through the other. If both windows sit at the same base, an access still reaches the RAM exactly once.

Top module: `dual_window_ocm`

## Requirements
- R1: After synchronous reset all four registers read as zero, and no access hits on either side.
- R2: The register select codes are 0 = instruction base, 1 = instruction control, 2 = data base and 3 = data control. A base register keeps only write-data bits 31:26, and its bits 25:0 read back as zero.
- R3: A control register keeps only write-data bits 31:30, and its other bits read back as zero. Bit 31 enables the window, and a window with bit 31 clear never hits.
- R4: A write with select code 2 or 3 changes only data-side registers. A write with select code 0 or 1 changes only instruction-side registers.
- R5: An access hits only when the window for its side (acc_side 0 = instruction, 1 = data) is enabled and address bits 31:26 equal that window's base. The window of the other side is never consulted.
- R6: On a hit the offset output equals address bits 11:0, so the 4 KiB RAM repeats across the whole 64 MB window. On a miss the offset output is zero.
- R7: Both windows alias one 4 KiB RAM: data written through one window reads back through the other at the same offset.
- R8: With both windows enabled at the same base, every access reaches the single RAM exactly once and reads return the last written word.
- R9: A register write becomes visible on the register read port and in the decode after the next rising clock edge, and not before it.
- R10: A read that hits returns its data with acc_rvalid high in the following cycle. A write that misses leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 ibase, 1 ictl, 2 dbase, 3 dctl) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_side | input | 1 | 0 instruction side, 1 data side |
| acc_addr | input | 32 | Access byte address |
| acc_we | input | 1 | Access is a write |
| acc_wdata | input | 32 | Access write data (whole word) |
| acc_hit | output | 1 | Access falls in the window of its side |
| acc_offset | output | 12 | RAM byte offset on a hit, zero otherwise |
| acc_rdata | output | 32 | Read data, one cycle after a hit read |
| acc_rvalid | output | 1 | acc_rdata is valid |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 6-bit base field and a 12-bit offset. With a 6-bit base there are only 64 placements, so the bench walks the instruction window through every one of them. At each placement it probes a matching address, the neighbouring slot, and the same address on the data side. Aliasing, placement of both windows at one base, disabled windows and missed writes are then exercised by writing through one window and reading through the other at offsets that differ only above bit 11.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

    localparam int NUM_WIN = 2;

    typedef enum logic [1:0] {
        SEL_IBASE = 2'd0,
        SEL_ICTL  = 2'd1,
        SEL_DBASE = 2'd2,
        SEL_DCTL  = 2'd3
    } ocm_sel_e;

    typedef enum logic {
        SIDE_INSN = 1'b0,
        SIDE_DATA = 1'b1
    } ocm_side_e;

    typedef struct packed {
        logic en;
        logic aux;
    } win_ctl_t;

    function automatic logic sel_is_ctl(input logic [1:0] sel);
        return sel[0];
    endfunction

    function automatic logic sel_window(input logic [1:0] sel);
        return sel[1];
    endfunction

endpackage

// File: rtl/ocm_regfile.sv
module ocm_regfile
    import ocm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [1:0]                        sel,
    input  logic [ADDR_W-1:0]                 wdata,
    output logic [ADDR_W-1:0]                 rdata,
    output logic [NUM_WIN-1:0][BASE_W-1:0]    base_q,
    output win_ctl_t [NUM_WIN-1:0]            ctl_q
);
    localparam int LOW_W = ADDR_W - BASE_W;

    logic [BASE_W-1:0] wr_base;
    win_ctl_t          wr_ctl;

    assign wr_base = wdata[ADDR_W-1 -: BASE_W];
    assign wr_ctl  = '{en: wdata[ADDR_W-1], aux: wdata[ADDR_W-2]};

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic hit_base, hit_ctl;
        assign hit_base = we && (sel_window(sel) == 1'(w)) && !sel_is_ctl(sel);
        assign hit_ctl  = we && (sel_window(sel) == 1'(w)) &&  sel_is_ctl(sel);

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[w] <= '0;
                ctl_q[w]  <= '0;
            end else begin
                if (hit_base) base_q[w] <= wr_base;
                if (hit_ctl)  ctl_q[w]  <= wr_ctl;
            end
        end

        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (base_q[w] == '0 && ctl_q[w] == '0)); // R1

        AST_BASE_WR_NEXT: assert property (@(posedge clk) disable iff (rst)
            (we && sel == {1'(w), 1'b0}) |=> base_q[w] == $past(wdata[ADDR_W-1 -: BASE_W])); // R9

        AST_SIDE_ISOLATE: assert property (@(posedge clk) disable iff (rst)
            (we && sel[1] != 1'(w)) |=> ($stable(base_q[w]) && $stable(ctl_q[w]))); // R4
    end

    always_comb begin
        win_ctl_t c;
        c = ctl_q[sel_window(sel)];
        if (sel_is_ctl(sel))
            rdata = {c.en, c.aux, {(ADDR_W-2){1'b0}}};
        else
            rdata = {base_q[sel_window(sel)], {LOW_W{1'b0}}};
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata[LOW_W-1:0];

endmodule

// File: rtl/ocm_window_match.sv
module ocm_window_match #(
    parameter int BASE_W = 6
) (
    input  logic              req,
    input  logic              enable,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [BASE_W-1:0] addr_top,
    output logic              hit
);
    assign hit = req && enable && (addr_top == cfg_base);
endmodule

// File: rtl/ocm_ram.sv
module ocm_ram #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int BYTE_LSB = $clog2(DATA_W / 8);
    localparam int IDX_W    = OFF_W - BYTE_LSB;
    localparam int DEPTH    = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx = offset[OFF_W-1:BYTE_LSB];

    always_ff @(posedge clk) begin
        if (en && we) mem[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= en && !we;
            if (en && !we) rdata <= mem[idx];
        end
    end

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        (en && !we) |=> rvalid); // R10

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(en && !we)); // R10

    logic unused_byte;
    assign unused_byte = ^offset[BYTE_LSB-1:0];

endmodule

// File: rtl/dual_window_ocm.sv
module dual_window_ocm
    import ocm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 6,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_side,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_hit,
    output logic [OFF_W-1:0]  acc_offset,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_rvalid
);
    logic [NUM_WIN-1:0][BASE_W-1:0] base_q;
    win_ctl_t [NUM_WIN-1:0]         ctl_q;
    logic [NUM_WIN-1:0]             win_sel;
    logic [BASE_W-1:0]              addr_top;

    assign addr_top = acc_addr[ADDR_W-1 -: BASE_W];

    ocm_regfile #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .base_q (base_q),
        .ctl_q  (ctl_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        ocm_window_match #(.BASE_W(BASE_W)) u_match (
            .req      (acc_valid && (acc_side == 1'(w))),
            .enable   (ctl_q[w].en),
            .cfg_base (base_q[w]),
            .addr_top (addr_top),
            .hit      (win_sel[w])
        );
    end

    assign acc_hit    = |win_sel;
    assign acc_offset = acc_hit ? acc_addr[OFF_W-1:0] : '0;

    ocm_ram #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_ram (
        .clk    (clk),
        .rst    (rst),
        .en     (acc_hit),
        .we     (acc_we),
        .offset (acc_addr[OFF_W-1:0]),
        .wdata  (acc_wdata),
        .rdata  (acc_rdata),
        .rvalid (acc_rvalid)
    );

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_sel)); // R8

    AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> ctl_q[acc_side].en); // R3

    AST_OFF_ZERO_MISS: assert property (@(posedge clk) disable iff (rst)
        !acc_hit |-> acc_offset == '0); // R6

    logic unused_mid;
    assign unused_mid = ^acc_addr[ADDR_W-BASE_W-1:OFF_W];

endmodule

// File: tb/dual_window_ocm_test.sv
module dual_window_ocm_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_side = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_we = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        acc_hit;
    logic [11:0] acc_offset;
    logic [31:0] acc_rdata;
    logic        acc_rvalid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_window_ocm uut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_side(acc_side), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_hit(acc_hit),
        .acc_offset(acc_offset), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input string req, input logic [1:0] sel, input logic [31:0] exp);
        @(negedge clk);
        reg_sel = sel;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic probe(input string req, input logic side, input logic [31:0] addr,
                         input logic exp_hit);
        @(negedge clk);
        acc_valid = 1'b1; acc_side = side; acc_addr = addr; acc_we = 1'b0;
        #1;
        check(req, {31'd0, acc_hit}, {31'd0, exp_hit});
        check(req, {20'd0, acc_offset}, exp_hit ? {20'd0, addr[11:0]} : 32'd0);
        acc_valid = 1'b0;
    endtask

    task automatic ram_wr(input logic side, input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b1; acc_side = side; acc_addr = addr; acc_we = 1'b1; acc_wdata = data;
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
    endtask

    task automatic ram_rd(input string req, input logic side, input logic [31:0] addr,
                          input logic [31:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_side = side; acc_addr = addr; acc_we = 1'b0;
        @(negedge clk);
        #1;
        check(req, {31'd0, acc_rvalid}, 32'd1);
        check(req, acc_rdata, exp);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < 4; s++) reg_rd("R1", 2'(s), 32'h0);
        probe("R1", 1'b0, 32'h0000_0040, 1'b0);
        probe("R1", 1'b1, 32'h0000_0040, 1'b0);

        // R3: control keeps only top two bits; aux alone does not enable
        reg_wr(2'd1, 32'hFFFF_FFFF);
        reg_rd("R3", 2'd1, 32'hC000_0000);
        reg_wr(2'd3, 32'h7FFF_FFFF);
        reg_rd("R3", 2'd3, 32'h4000_0000);
        probe("R3", 1'b1, 32'h0000_0080, 1'b0);

        // R4 and R2: data writes leave the instruction registers alone
        reg_wr(2'd2, 32'hFFFF_FFFF);
        reg_rd("R2", 2'd2, 32'hFC00_0000);
        reg_rd("R4", 2'd0, 32'h0);
        reg_rd("R4", 2'd1, 32'hC000_0000);
        reg_wr(2'd0, 32'h0400_0000);
        reg_rd("R4", 2'd2, 32'hFC00_0000);
        reg_rd("R4", 2'd3, 32'h4000_0000);

        // data window at slot 20, enabled
        reg_wr(2'd2, {6'd20, 26'h155_5555});
        reg_wr(2'd3, 32'h8000_0000);

        // R2, R5, R6: instruction window through every base slot
        for (int b = 0; b < 64; b++) begin
            logic [31:0] a;
            a = {6'(b), 14'(b * 37 + 5), 12'(b * 97 + 3)};
            reg_wr(2'd0, {6'(b), 26'h3FF_FFFF});
            reg_rd("R2", 2'd0, {6'(b), 26'h0});
            probe("R5", 1'b0, a, 1'b1);
            probe("R5", 1'b0, {6'(b) ^ 6'd1, a[25:0]}, 1'b0);
            probe("R5", 1'b1, a, b == 20);
        end

        // R9: a register write is not visible before the edge
        @(negedge clk);
        reg_sel = 2'd0; reg_we = 1'b1; reg_wdata = {6'd5, 26'h0};
        #1 check("R9", reg_rdata, {6'd63, 26'h0});
        probe("R9", 1'b0, {6'd5, 26'h10}, 1'b1);
        reg_we = 1'b0;
        reg_rd("R9", 2'd0, {6'd5, 26'h0});

        // R7, R6: aliasing across windows and repetition in the window
        reg_wr(2'd2, {6'd9, 26'h0});
        ram_wr(1'b0, {6'd5, 14'h0, 12'h100}, 32'hA5A5_0001);
        ram_rd("R7", 1'b1, {6'd9, 14'h0, 12'h100}, 32'hA5A5_0001);
        ram_rd("R6", 1'b1, {6'd9, 14'h2AB, 12'h100}, 32'hA5A5_0001);
        ram_rd("R6", 1'b0, {6'd5, 14'h3FFF, 12'h100}, 32'hA5A5_0001);

        // R8: both windows at the same base
        reg_wr(2'd2, {6'd5, 26'h0});
        ram_wr(1'b1, {6'd5, 14'h0, 12'h200}, 32'h0BAD_F00D);
        ram_rd("R8", 1'b0, {6'd5, 14'h0, 12'h200}, 32'h0BAD_F00D);
        ram_wr(1'b0, {6'd5, 14'h1, 12'h200}, 32'h1234_5678);
        ram_rd("R8", 1'b1, {6'd5, 14'h0, 12'h200}, 32'h1234_5678);

        // R10: missed writes leave the RAM unchanged
        ram_wr(1'b0, {6'd7, 14'h0, 12'h100}, 32'hDEAD_0000);
        ram_rd("R10", 1'b1, {6'd5, 14'h0, 12'h100}, 32'hA5A5_0001);
        reg_wr(2'd1, 32'h0);
        probe("R3", 1'b0, {6'd5, 14'h0, 12'h100}, 1'b0);
        ram_wr(1'b0, {6'd5, 14'h0, 12'h100}, 32'hDEAD_0001);
        ram_rd("R10", 1'b1, {6'd5, 14'h0, 12'h100}, 32'hA5A5_0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule